// File: doc/BRIEF.md
# Override-Gated Output Multiplexer Stage

This block drives a small set of device outputs from a five-bit configuration word held elsewhere. The low four bits of the word compete with a four-bit parallel input bus for four multiplexed outputs, and a select input chooses between them. The top bit of the word drives one extra output that takes no part in the multiplexing. An active-low override input clears every output that is fed from the word. It has no effect on the path from the parallel bus.

The extra output is frozen when select rises. While the parallel bus is chosen, that output keeps the level it showed just before the switch. The block keeps a shadow copy of the configuration word, and a write-busy input stops that copy from updating. The outputs therefore never show a word that is only partly written, and a new word appears only once the write ends.

The select input is asynchronous and passes through a synchronizer. The override input and the parallel bus reach the outputs through logic only, with no register on the way. All pins are plain level signals, so there is no handshake and no back-pressure.

Top module: `ovr_mux_stage`

## Requirements
- R1: While the synchronized select is low and `ovr_n_i` is low, `mux_o` is 4'b0000 and `solo_o` is 0.
- R2: While the synchronized select is low and `ovr_n_i` is high, `mux_o[i]` equals shadow bit i for i = 0..3, and `solo_o` equals shadow bit 4.
- R3: While the synchronized select is high, `mux_o` equals `par_i` in the same cycle, whatever the level of `ovr_n_i`.
- R4: While the synchronized select is high, `solo_o` holds the level it had in the last cycle before select took effect. Changes to `cfg_i` or to `ovr_n_i` during that time do not alter it.
- R5: While `wr_busy_i` is high, the shadow copy does not change, and `cfg_i` changes do not reach the outputs. The first clock edge with `wr_busy_i` low loads the current `cfg_i`.
- R6: Reset clears the shadow copy, the held bit and the synchronizer. With select low, all outputs are low during reset and in the first cycle after it, whatever the level of `cfg_i`.
- R7: A change on `sel_i` reaches the outputs on the second rising clock edge after it. The path from `ovr_n_i` and `par_i` to the outputs has no register.
- R8: With `wr_busy_i` low, a change on `cfg_i` reaches the outputs on the first rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 5 | Stored configuration word; bit 4 feeds `solo_o`, bits 3..0 feed `mux_o` |
| par_i | input | 4 | Parallel input bus |
| sel_i | input | 1 | Asynchronous select; high chooses `par_i` |
| ovr_n_i | input | 1 | Active-low override of the stored-word path |
| wr_busy_i | input | 1 | High while the stored word is being written |
| mux_o | output | 4 | Multiplexed outputs |
| solo_o | output | 1 | Non-multiplexed output |

## Verification
The results fall due at three different times. A change on `ovr_n_i` or `par_i` shows at the outputs in the same cycle. A change on `cfg_i` shows one rising edge later, and a change on `sel_i` shows two rising edges later. The bench drives every input on a falling edge and samples only on a later falling edge. The table rows wait three edges before sampling, which covers all three delays. The directed tests sample at the exact edge counts: one edge and then two edges after select rises, one edge after busy falls, and at the end of a busy window three edges long.

// File: rtl/ovr_mux_pkg.sv
package ovr_mux_pkg;
  localparam int DEF_MUX_W  = 4;
  localparam int DEF_STAGES = 2;

  // Source chosen for the multiplexed outputs
  typedef enum logic [1:0] {
    PATH_CLEAR = 2'd0,
    PATH_STORE = 2'd1,
    PATH_PAR   = 2'd2
  } path_e;
endpackage

// File: rtl/oms_sel_sync.sv
module oms_sel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  output logic sel_s,
  output logic rise_next
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= sel_i;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign sel_s     = chain_q[LAST];
  // The final stage takes a rising value at the coming edge
  assign rise_next = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/oms_shadow.sv
module oms_shadow #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (!busy) q <= din;
  end
endmodule

// File: rtl/oms_hold.sv
module oms_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic cur,
  output logic held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= 1'b0;
    else if (capture) held <= cur;
  end
endmodule

// File: rtl/oms_outmux.sv
module oms_outmux
  import ovr_mux_pkg::*;
#(
  parameter int W = 4
) (
  input  path_e        path,
  input  logic [W-1:0] store,
  input  logic [W-1:0] par,
  output logic [W-1:0] dout
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      always_comb begin
        unique case (path)
          PATH_STORE: dout[g] = store[g];
          PATH_PAR:   dout[g] = par[g];
          default:    dout[g] = 1'b0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/ovr_mux_stage.sv
module ovr_mux_stage
  import ovr_mux_pkg::*;
#(
  parameter int MUX_W  = DEF_MUX_W,
  parameter int STAGES = DEF_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MUX_W:0]   cfg_i,
  input  logic [MUX_W-1:0] par_i,
  input  logic             sel_i,
  input  logic             ovr_n_i,
  input  logic             wr_busy_i,
  output logic [MUX_W-1:0] mux_o,
  output logic             solo_o
);
  localparam int WORD_W = MUX_W + 1;
  localparam int SOLO_B = MUX_W;

  logic              sel_s;
  logic              rise_next;
  logic [WORD_W-1:0] shadow_q;
  logic              held_q;
  logic              solo_live;
  path_e             path;

  oms_sel_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i),
    .sel_s(sel_s), .rise_next(rise_next)
  );

  oms_shadow #(.W(WORD_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .busy(wr_busy_i), .din(cfg_i), .q(shadow_q)
  );

  // Level shown on the extra output while the stored path is chosen
  assign solo_live = ovr_n_i & shadow_q[SOLO_B];

  oms_hold u_hold (
    .clk(clk), .rst_n(rst_n), .capture(rise_next),
    .cur(solo_live), .held(held_q)
  );

  always_comb begin
    if (sel_s)        path = PATH_PAR;
    else if (ovr_n_i) path = PATH_STORE;
    else              path = PATH_CLEAR;
  end

  oms_outmux #(.W(MUX_W)) u_mux (
    .path(path), .store(shadow_q[MUX_W-1:0]), .par(par_i), .dout(mux_o)
  );

  assign solo_o = sel_s ? held_q : solo_live;
endmodule

// File: rtl/ovr_mux_stage_chk.sv
module ovr_mux_stage_chk #(
  parameter int MUX_W  = 4,
  parameter int STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [MUX_W:0]   cfg_i,
  input logic [MUX_W-1:0] par_i,
  input logic             sel_i,
  input logic             ovr_n_i,
  input logic             wr_busy_i,
  input logic [MUX_W-1:0] mux_o,
  input logic             solo_o,
  input logic             sel_s,
  input logic [MUX_W:0]   shadow_q
);
  logic [7:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 8'hFF) age_q <= age_q + 8'd1;
  end

  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_s && !ovr_n_i) |-> (mux_o == '0 && !solo_o)); // R1

  AST_STORE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_s && ovr_n_i) |-> ({solo_o, mux_o} == shadow_q)); // R2

  AST_PAR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |-> (mux_o == par_i)); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 8'd1 && sel_s && $past(sel_s)) |-> $stable(solo_o)); // R4

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 8'd1 && $past(wr_busy_i)) |-> $stable(shadow_q)); // R5

  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 8'd1 && !$past(wr_busy_i)) |-> (shadow_q == $past(cfg_i))); // R8

  AST_SEL_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 8'd2 && STAGES == 2) |-> (sel_s == $past(sel_i, 2))); // R7
endmodule

bind ovr_mux_stage ovr_mux_stage_chk #(.MUX_W(MUX_W), .STAGES(STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .par_i(par_i), .sel_i(sel_i),
  .ovr_n_i(ovr_n_i), .wr_busy_i(wr_busy_i), .mux_o(mux_o), .solo_o(solo_o),
  .sel_s(sel_s), .shadow_q(shadow_q)
);

// File: tb/ovr_mux_stage_tb.sv
module ovr_mux_stage_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] cfg_i = 5'b10101;
  logic [3:0] par_i = 4'b0000;
  logic       sel_i = 1'b0;
  logic       ovr_n_i = 1'b1;
  logic       wr_busy_i = 1'b0;
  logic [3:0] mux_o;
  logic       solo_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ovr_mux_stage u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .par_i(par_i), .sel_i(sel_i),
    .ovr_n_i(ovr_n_i), .wr_busy_i(wr_busy_i), .mux_o(mux_o), .solo_o(solo_o)
  );

  // {sel, ovr_n, cfg[4:0], par[3:0], exp_mux[3:0], exp_solo}, applied in order
  localparam logic [15:0] VEC [10] = '{
    {1'b0, 1'b1, 5'b10101, 4'b1010, 4'b0101, 1'b1},
    {1'b0, 1'b0, 5'b10101, 4'b1010, 4'b0000, 1'b0},
    {1'b1, 1'b0, 5'b10101, 4'b1010, 4'b1010, 1'b0},
    {1'b1, 1'b1, 5'b10101, 4'b0110, 4'b0110, 1'b0},
    {1'b0, 1'b1, 5'b11100, 4'b0110, 4'b1100, 1'b1},
    {1'b1, 1'b1, 5'b11100, 4'b0011, 4'b0011, 1'b1},
    {1'b1, 1'b0, 5'b00001, 4'b1111, 4'b1111, 1'b1},
    {1'b0, 1'b1, 5'b00001, 4'b1111, 4'b0001, 1'b0},
    {1'b0, 1'b0, 5'b00001, 4'b1111, 4'b0000, 1'b0},
    {1'b1, 1'b0, 5'b00001, 4'b0000, 4'b0000, 1'b0}
  };

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic [3:0] em, input logic es);
    n_chk++;
    if (mux_o !== em || solo_o !== es) begin
      n_bad++;
      $display("FAIL %s: mux=%b solo=%b expected mux=%b solo=%b",
               req, mux_o, solo_o, em, es);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R6: outputs low during reset although cfg_i is nonzero and override is high
    edges(3);
    check("R6 in reset", 4'b0000, 1'b0);
    rst_n = 1'b1;
    #1;
    check("R6 first cycle after reset", 4'b0000, 1'b0);
    edges(1);
    // R8: the word shows one edge after reset ends
    check("R8 load after reset", 4'b0101, 1'b1);

    // Table walk: R1, R2, R3, R4 across all select/override levels
    for (int k = 0; k < 10; k++) begin
      {sel_i, ovr_n_i, cfg_i, par_i} = VEC[k][15:5];
      edges(3);
      check($sformatf("R1/R2/R3/R4 row %0d", k), VEC[k][4:1], VEC[k][0]);
    end

    // R7: select needs two edges; override path has no register
    sel_i = 1'b0; ovr_n_i = 1'b1; cfg_i = 5'b01001; par_i = 4'b0110;
    edges(3);
    check("R2 setup", 4'b1001, 1'b0);
    sel_i = 1'b1;
    edges(1);
    check("R7 one edge after select", 4'b1001, 1'b0);
    edges(1);
    check("R7 two edges after select", 4'b0110, 1'b0);
    sel_i = 1'b0;
    edges(2);
    ovr_n_i = 1'b0;
    #1;
    check("R7 override same cycle", 4'b0000, 1'b0);
    ovr_n_i = 1'b1;

    // R5: word change during busy stays hidden
    wr_busy_i = 1'b1;
    cfg_i = 5'b10110;
    edges(3);
    check("R5 busy holds old word", 4'b1001, 1'b0);
    wr_busy_i = 1'b0;
    edges(1);
    check("R5 word applied after busy", 4'b0110, 1'b1);

    // R4: hold captured from override-high level survives later changes
    sel_i = 1'b1;
    edges(3);
    check("R4 hold captured", 4'b0110, 1'b1);
    cfg_i = 5'b00000; ovr_n_i = 1'b0;
    edges(3);
    check("R4 hold unaffected", 4'b0110, 1'b1);
    sel_i = 1'b0; ovr_n_i = 1'b1;
    edges(3);
    check("R8 new word after select drops", 4'b0000, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule